// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block sits in front of a two-wire register master and lets a host reach the registers of up to five internal PHYs through a window. For each host command it runs a short chain of master transactions. First it writes a control register that selects the direction. Next it writes to a computed window address that encodes the PHY, page and register. For a read, it then fetches the result from a data register. It returns the result with a one-cycle completion pulse and an error flag.

Several host command types are available:
- Raw indirect read and raw indirect write.
- An MDIO-style read, which always uses page 0 and returns all ones on failure.
- An MDIO-style write, which always uses page 0 and is always followed by a flushing read-back of the same register.
- A start-up probe, which checks the chip identity word and reports the chip version.

The serial framing and the register master are outside this block. The block connects to the master through a request/done interface with one request outstanding at a time.

Top module: `phy_window_seq`

## Requirements
- R1: A command is rejected, with host_err=1 and no master request, when the PHY number is above 4, the page is above 7 (raw commands only), the register index is above 31, or host_op is not one of 0=raw read, 1=raw write, 2=MDIO read, 3=MDIO write, 4=probe.
- R2: The first transaction of every access pass is a master write (m_wr=1) to address 0x8028 with data 1 for a read pass and 0 for a write pass.
- R3: The second transaction is a master write to a window address with bit 15 set, bit (9+PHY) set, the page in bits 7:5 and the register in bits 4:0. Its data is the host write data for a write pass and 0 for a read pass.
- R4: A read pass ends with a master read (m_wr=0) of address 0x8029, whose data is returned on host_rdata with host_err=0.
- R5: A master transaction that ends with m_err=1 stops the pass at once, with no further transaction of that pass, and the command ends with host_err=1.
- R6: MDIO-style reads use page 0 whatever host_page holds, and a failed or rejected one returns host_rdata=0xFFFF with host_err=1.
- R7: An MDIO-style write is always followed by a full read pass of the same PHY register at page 0, even when the write pass failed. host_err reports only the write pass, and host_rdata is 0.
- R8: The probe reads address 0x0105. If the value is not 0x8366 it ends with host_err=1 without another transaction. Otherwise it reads 0x0104 and returns that value's low 4 bits, zero-extended.
- R9: host_done is a single-cycle pulse. A rejected command completes with host_done two cycles after host_req is sampled. Writes and failed non-MDIO reads return host_rdata=0.
- R10: m_req is a one-cycle pulse with at most one request outstanding, and only while busy. A host_req that arrives while host_busy=1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Command strobe, taken when idle |
| host_op | input | 3 | Command type (see R1) |
| host_phy | input | 5 | PHY number |
| host_page | input | 4 | Page (raw commands only) |
| host_reg | input | 6 | Register index |
| host_wdata | input | 16 | Write data |
| host_busy | output | 1 | A command is in progress |
| host_done | output | 1 | Completion pulse |
| host_err | output | 1 | Error flag, valid with host_done |
| host_rdata | output | 16 | Result, valid with host_done |
| m_req | output | 1 | Request to the register master |
| m_wr | output | 1 | 1 = master write, 0 = master read |
| m_addr | output | 16 | Master register address |
| m_wdata | output | 16 | Master write data |
| m_done | input | 1 | Master completion pulse |
| m_err | input | 1 | Master transaction failed |
| m_rdata | input | 16 | Master read data |

## Verification
A wrong state or pass flag shows on the master port at the very next request: the wrong address, a control value of 1 where 0 was due, or a missing or extra transaction. A model of the register master compares each request in order against a queue of expected ones, so the divergence is caught in the cycle it is issued. A wrong error or flush decision shows only at the completion pulse, through host_err, host_rdata, or a flush read that is absent. Fault injection at every transaction position makes each abort path reach the ports.

// File: rtl/pws_pkg.sv
package pws_pkg;

    localparam int DW        = 16;
    localparam int OP_W      = 3;
    localparam int PHY_W     = 5;
    localparam int PAGE_W    = 4;
    localparam int REG_W     = 6;
    localparam int MAX_PHY   = 4;
    localparam int MAX_PAGE  = 7;
    localparam int MAX_REG   = 31;
    localparam int NPHY      = MAX_PHY + 1;
    localparam int PAGE_BITS = $clog2(MAX_PAGE + 1);
    localparam int REG_BITS  = $clog2(MAX_REG + 1);
    localparam int SEL_LSB   = 9;
    localparam int PAGE_LSB  = 5;
    localparam int WIN_FLAG  = 15;
    localparam int VER_BITS  = 4;

    localparam logic [DW-1:0] CTRL_ADDR = 16'h8028;
    localparam logic [DW-1:0] DATA_ADDR = 16'h8029;
    localparam logic [DW-1:0] ID_ADDR   = 16'h0105;
    localparam logic [DW-1:0] VER_ADDR  = 16'h0104;
    localparam logic [DW-1:0] ID_VALUE  = 16'h8366;
    localparam logic [DW-1:0] ALL_ONES  = '1;

    typedef enum logic [OP_W-1:0] {
        OP_IND_RD = 3'd0,
        OP_IND_WR = 3'd1,
        OP_MII_RD = 3'd2,
        OP_MII_WR = 3'd3,
        OP_PROBE  = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_CTRL_WR, S_ADDR_WR,
        S_DATA_RD, S_ID_RD, S_VER_RD, S_DONE
    } st_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [PHY_W-1:0]  phy;
        logic [PAGE_W-1:0] page;
        logic [REG_W-1:0]  regi;
        logic [DW-1:0]     wdata;
    } cmd_t;

    typedef struct packed {
        logic          req;
        logic          wr;
        logic [DW-1:0] addr;
        logic [DW-1:0] data;
    } bus_req_t;

    function automatic logic is_mii(input logic [OP_W-1:0] op);
        return (op == OP_MII_RD) || (op == OP_MII_WR);
    endfunction

    function automatic logic is_read(input logic [OP_W-1:0] op);
        return (op == OP_IND_RD) || (op == OP_MII_RD);
    endfunction

endpackage

// File: rtl/pws_range_chk.sv
module pws_range_chk
    import pws_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [PHY_W-1:0]  phy,
    input  logic [PAGE_W-1:0] page,
    input  logic [REG_W-1:0]  regi,
    output logic              ok
);
    logic op_ok, phy_ok, page_ok, reg_ok;

    always_comb begin
        op_ok   = (op <= OP_MII_WR);
        phy_ok  = (phy  <= PHY_W'(MAX_PHY));
        page_ok = (page <= PAGE_W'(MAX_PAGE));
        reg_ok  = (regi <= REG_W'(MAX_REG));
        ok      = op_ok && phy_ok && page_ok && reg_ok;
    end
endmodule

// File: rtl/pws_addr_build.sv
module pws_addr_build
    import pws_pkg::*;
(
    input  logic [PHY_W-1:0]  phy,
    input  logic [PAGE_W-1:0] page,
    input  logic [REG_W-1:0]  regi,
    output logic [DW-1:0]     win_addr
);
    logic [NPHY-1:0] sel;

    for (genvar g = 0; g < NPHY; g++) begin : g_sel
        assign sel[g] = (phy == PHY_W'(g));
    end

    always_comb begin
        win_addr = '0;
        win_addr[WIN_FLAG] = 1'b1;
        win_addr[SEL_LSB +: NPHY] = sel;
        win_addr[PAGE_LSB +: PAGE_BITS] = page[PAGE_BITS-1:0];
        win_addr[REG_BITS-1:0] = regi[REG_BITS-1:0];
    end
endmodule

// File: rtl/pws_fsm.sv
module pws_fsm
    import pws_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          host_req,
    input  cmd_t          cmd_in,
    input  logic          range_ok,
    input  logic [DW-1:0] win_addr,
    output cmd_t          cmd_q,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output bus_req_t      bus,
    input  logic          m_done,
    input  logic          m_err,
    input  logic [DW-1:0] m_rdata
);
    st_e           st;
    logic          pend;
    logic          rd_pass;
    logic          wr_err;
    logic          err_q;
    logic [DW-1:0] rdata_q;
    logic          bus_st;
    logic          step_ok;
    logic          step_fail;
    logic          op_mii_rd;
    logic          op_mii_wr;

    always_comb begin
        bus_st    = (st == S_CTRL_WR) || (st == S_ADDR_WR) || (st == S_DATA_RD) ||
                    (st == S_ID_RD)   || (st == S_VER_RD);
        step_ok   = bus_st && pend && m_done && !m_err;
        step_fail = bus_st && pend && m_done && m_err;
        op_mii_rd = (cmd_q.op == OP_MII_RD);
        op_mii_wr = (cmd_q.op == OP_MII_WR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            cmd_q   <= '0;
            pend    <= 1'b0;
            rd_pass <= 1'b0;
            wr_err  <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (bus_st && !pend)
                pend <= 1'b1;
            else if (bus_st && m_done)
                pend <= 1'b0;

            if (step_fail) begin
                if (op_mii_wr && !rd_pass) begin
                    wr_err  <= 1'b1;
                    rd_pass <= 1'b1;
                    st      <= S_CTRL_WR;
                end else begin
                    err_q   <= op_mii_wr ? wr_err : 1'b1;
                    rdata_q <= op_mii_rd ? ALL_ONES : '0;
                    st      <= S_DONE;
                end
            end else begin
                case (st)
                    S_IDLE: begin
                        if (host_req) begin
                            cmd_q   <= cmd_in;
                            err_q   <= 1'b0;
                            rdata_q <= '0;
                            wr_err  <= 1'b0;
                            rd_pass <= 1'b0;
                            st      <= S_CHECK;
                        end
                    end
                    S_CHECK: begin
                        if (cmd_q.op == OP_PROBE) begin
                            st <= S_ID_RD;
                        end else if (!range_ok) begin
                            err_q   <= 1'b1;
                            rdata_q <= op_mii_rd ? ALL_ONES : '0;
                            st      <= S_DONE;
                        end else begin
                            rd_pass <= is_read(cmd_q.op);
                            st      <= S_CTRL_WR;
                        end
                    end
                    S_CTRL_WR: if (step_ok) st <= S_ADDR_WR;
                    S_ADDR_WR: begin
                        if (step_ok) begin
                            if (rd_pass) begin
                                st <= S_DATA_RD;
                            end else if (op_mii_wr) begin
                                rd_pass <= 1'b1;
                                st      <= S_CTRL_WR;
                            end else begin
                                st <= S_DONE;
                            end
                        end
                    end
                    S_DATA_RD: begin
                        if (step_ok) begin
                            if (op_mii_wr) begin
                                err_q   <= wr_err;
                                rdata_q <= '0;
                            end else begin
                                rdata_q <= m_rdata;
                            end
                            st <= S_DONE;
                        end
                    end
                    S_ID_RD: begin
                        if (step_ok) begin
                            if (m_rdata != ID_VALUE) begin
                                err_q <= 1'b1;
                                st    <= S_DONE;
                            end else begin
                                st <= S_VER_RD;
                            end
                        end
                    end
                    S_VER_RD: begin
                        if (step_ok) begin
                            rdata_q <= {{(DW-VER_BITS){1'b0}}, m_rdata[VER_BITS-1:0]};
                            st      <= S_DONE;
                        end
                    end
                    S_DONE:  st <= S_IDLE;
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        bus      = '0;
        bus.req  = bus_st && !pend;
        case (st)
            S_CTRL_WR: begin
                bus.wr   = 1'b1;
                bus.addr = CTRL_ADDR;
                bus.data = rd_pass ? DW'(1) : '0;
            end
            S_ADDR_WR: begin
                bus.wr   = 1'b1;
                bus.addr = win_addr;
                bus.data = rd_pass ? '0 : cmd_q.wdata;
            end
            S_DATA_RD: bus.addr = DATA_ADDR;
            S_ID_RD:   bus.addr = ID_ADDR;
            S_VER_RD:  bus.addr = VER_ADDR;
            default:   bus.addr = '0;
        endcase
    end

    assign busy  = (st != S_IDLE);
    assign done  = (st == S_DONE);
    assign err   = err_q;
    assign rdata = rdata_q;
endmodule

// File: rtl/phy_window_seq.sv
module phy_window_seq
    import pws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_req,
    input  logic [OP_W-1:0]   host_op,
    input  logic [PHY_W-1:0]  host_phy,
    input  logic [PAGE_W-1:0] host_page,
    input  logic [REG_W-1:0]  host_reg,
    input  logic [DW-1:0]     host_wdata,
    output logic              host_busy,
    output logic              host_done,
    output logic              host_err,
    output logic [DW-1:0]     host_rdata,
    output logic              m_req,
    output logic              m_wr,
    output logic [DW-1:0]     m_addr,
    output logic [DW-1:0]     m_wdata,
    input  logic              m_done,
    input  logic              m_err,
    input  logic [DW-1:0]     m_rdata
);
    cmd_t          cmd_in;
    cmd_t          cmd_q;
    logic          range_ok;
    logic [DW-1:0] win_addr;
    bus_req_t      bus;

    always_comb begin
        cmd_in.op    = host_op;
        cmd_in.phy   = host_phy;
        cmd_in.page  = is_mii(host_op) ? '0 : host_page;
        cmd_in.regi  = host_reg;
        cmd_in.wdata = host_wdata;
    end

    pws_range_chk u_range (
        .op   (cmd_q.op),
        .phy  (cmd_q.phy),
        .page (cmd_q.page),
        .regi (cmd_q.regi),
        .ok   (range_ok)
    );

    pws_addr_build u_addr (
        .phy      (cmd_q.phy),
        .page     (cmd_q.page),
        .regi     (cmd_q.regi),
        .win_addr (win_addr)
    );

    pws_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .host_req (host_req),
        .cmd_in   (cmd_in),
        .range_ok (range_ok),
        .win_addr (win_addr),
        .cmd_q    (cmd_q),
        .busy     (host_busy),
        .done     (host_done),
        .err      (host_err),
        .rdata    (host_rdata),
        .bus      (bus),
        .m_done   (m_done),
        .m_err    (m_err),
        .m_rdata  (m_rdata)
    );

    assign m_req   = bus.req;
    assign m_wr    = bus.wr;
    assign m_addr  = bus.addr;
    assign m_wdata = bus.data;
endmodule

// File: rtl/pws_checker.sv
module pws_checker
    import pws_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              host_req,
    input logic              host_busy,
    input logic [OP_W-1:0]   host_op,
    input logic [PHY_W-1:0]  host_phy,
    input logic [PAGE_W-1:0] host_page,
    input logic [REG_W-1:0]  host_reg,
    input logic              host_done,
    input logic              host_err,
    input logic [DW-1:0]     host_rdata,
    input logic              m_req,
    input logic              m_wr,
    input logic [DW-1:0]     m_addr,
    input logic              m_done
);
    logic            bad_q;
    logic            saw_q;
    logic            outst_q;
    logic [OP_W-1:0] op_q;
    logic            bad_now;

    always_comb begin
        bad_now = (host_op != OP_PROBE) &&
                  ((host_op > OP_PROBE) || (host_phy > PHY_W'(MAX_PHY)) ||
                   (!is_mii(host_op) && (host_page > PAGE_W'(MAX_PAGE))) ||
                   (host_reg > REG_W'(MAX_REG)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_q   <= 1'b0;
            saw_q   <= 1'b0;
            outst_q <= 1'b0;
            op_q    <= '0;
        end else begin
            if (host_req && !host_busy) begin
                bad_q <= bad_now;
                op_q  <= host_op;
                saw_q <= 1'b0;
            end else if (m_req) begin
                saw_q <= 1'b1;
            end
            if (m_req)
                outst_q <= 1'b1;
            else if (m_done)
                outst_q <= 1'b0;
        end
    end

    // R1
    rej_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        host_done && bad_q |-> host_err && !saw_q);
    // R6
    mii_fail_ones_chk: assert property (@(posedge clk) disable iff (rst)
        host_done && host_err && (op_q == OP_MII_RD) |-> host_rdata == ALL_ONES);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        host_done |=> !host_done);
    // R10
    one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
        m_req |-> !outst_q);
    // R10
    req_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        m_req |-> host_busy);
    // R3
    win_flag_chk: assert property (@(posedge clk) disable iff (rst)
        m_req && m_wr |-> m_addr[WIN_FLAG]);
endmodule

bind phy_window_seq pws_checker u_pws_checker (
    .clk        (clk),
    .rst        (rst),
    .host_req   (host_req),
    .host_busy  (host_busy),
    .host_op    (host_op),
    .host_phy   (host_phy),
    .host_page  (host_page),
    .host_reg   (host_reg),
    .host_done  (host_done),
    .host_err   (host_err),
    .host_rdata (host_rdata),
    .m_req      (m_req),
    .m_wr       (m_wr),
    .m_addr     (m_addr),
    .m_done     (m_done)
);

// File: tb/phy_window_seq_tb_top.sv
module phy_window_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int WATCHDOG   = 50000;

    logic        clk, rst;
    logic        host_req;
    logic [2:0]  host_op;
    logic [4:0]  host_phy;
    logic [3:0]  host_page;
    logic [5:0]  host_reg;
    logic [15:0] host_wdata;
    logic        host_busy, host_done, host_err;
    logic [15:0] host_rdata;
    logic        m_req, m_wr;
    logic [15:0] m_addr, m_wdata;
    logic        m_done, m_err;
    logic [15:0] m_rdata;

    typedef struct {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
    } tx_t;

    tx_t         exp_q[$];
    int          checks = 0;
    int          fails = 0;
    int          tx_idx = 0;
    int          fail_at = -1;
    int          done_seen = 0;
    logic [15:0] phymem [0:1279];
    logic [15:0] ctrl_r, data_r, id_val, ver_val;

    phy_window_seq dut_i (
        .clk(clk), .rst(rst), .host_req(host_req), .host_op(host_op),
        .host_phy(host_phy), .host_page(host_page), .host_reg(host_reg),
        .host_wdata(host_wdata), .host_busy(host_busy), .host_done(host_done),
        .host_err(host_err), .host_rdata(host_rdata), .m_req(m_req), .m_wr(m_wr),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_done(m_done), .m_err(m_err),
        .m_rdata(m_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [15:0] a);
        if (a == 16'h8028) return "R2";
        if (a == 16'h8029) return "R4";
        if (a == 16'h0105 || a == 16'h0104) return "R8";
        return "R3";
    endfunction

    // register master model and scoreboard monitor
    initial begin
        m_done = 1'b0; m_err = 1'b0; m_rdata = '0;
        forever begin
            @(negedge clk);
            if (host_done) done_seen++;
            if (m_done) begin m_done = 1'b0; m_err = 1'b0; end
            if (m_req && !rst) begin
                logic bad;
                bad = 1'b0;
                if (exp_q.size() == 0) begin
                    chk(0, "R10", "unexpected master request", {m_wr, m_addr}, 0);
                end else begin
                    tx_t e;
                    e = exp_q.pop_front();
                    chk(m_wr == e.wr && m_addr == e.addr, tag_of(e.addr),
                        "request address/direction", {m_wr, m_addr}, {e.wr, e.addr});
                    if (e.wr)
                        chk(m_wdata == e.data, tag_of(e.addr), "request data", m_wdata, e.data);
                end
                if (tx_idx == fail_at) begin
                    bad = 1'b1;
                end else if (m_wr) begin
                    if (m_addr == 16'h8028) ctrl_r = m_wdata;
                    else if (m_addr == 16'h8029) data_r = m_wdata;
                    else if (m_addr[15]) begin
                        int p;
                        int idx;
                        p = 0;
                        for (int i = 0; i < 5; i++) if (m_addr[9+i]) p = i;
                        idx = p*256 + int'(m_addr[7:5])*32 + int'(m_addr[4:0]);
                        if (ctrl_r[0]) data_r = phymem[idx];
                        else phymem[idx] = m_wdata;
                    end
                end
                tx_idx++;
                repeat (LAT) @(negedge clk);
                if (host_done) done_seen++;
                m_err = bad;
                if (!m_wr_q_is_write(m_addr, bad))
                    m_rdata = read_val(m_addr);
                m_done = 1'b1;
            end
        end
    end

    function automatic bit m_wr_q_is_write(input logic [15:0] a, input logic b);
        return b || (a[15] && a != 16'h8029);
    endfunction

    function automatic logic [15:0] read_val(input logic [15:0] a);
        if (a == 16'h8029) return data_r;
        if (a == 16'h0105) return id_val;
        if (a == 16'h0104) return ver_val;
        return 16'hDEAD;
    endfunction

    task automatic add(input logic wr, input logic [15:0] a, input logic [15:0] d,
                       inout bit stop, inout int k, input int fail);
        tx_t t;
        if (!stop) begin
            t.wr = wr; t.addr = a; t.data = d;
            exp_q.push_back(t);
            if (k == fail) stop = 1;
            k++;
        end
    endtask

    task automatic run_op(input logic [2:0] op, input logic [4:0] phy,
                          input logic [3:0] page, input logic [5:0] regi,
                          input logic [15:0] wd, input int fail,
                          input logic exp_err, input logic [15:0] exp_rd,
                          input string tag, input int exp_lat, input bit poke);
        bit          stop;
        int          k;
        int          n;
        int          base;
        bit          mii;
        bit          valid;
        logic [3:0]  pg;
        logic [15:0] win;
        stop = 0; k = 0;
        mii = (op == 3'd2 || op == 3'd3);
        pg = mii ? 4'd0 : page;
        valid = (op == 3'd4) || (op <= 3'd3 && phy <= 5'd4 && pg <= 4'd7 && regi <= 6'd31);
        win = 16'h8000 | (16'd1 << (9 + int'(phy))) | (16'(pg[2:0]) << 5) | 16'(regi[4:0]);
        if (valid) begin
            case (op)
                3'd0, 3'd2: begin
                    add(1, 16'h8028, 16'd1, stop, k, fail);
                    add(1, win, 16'd0, stop, k, fail);
                    add(0, 16'h8029, 16'd0, stop, k, fail);
                end
                3'd1: begin
                    add(1, 16'h8028, 16'd0, stop, k, fail);
                    add(1, win, wd, stop, k, fail);
                end
                3'd3: begin
                    add(1, 16'h8028, 16'd0, stop, k, fail);
                    add(1, win, wd, stop, k, fail);
                    stop = 0;
                    add(1, 16'h8028, 16'd1, stop, k, fail);
                    add(1, win, 16'd0, stop, k, fail);
                    add(0, 16'h8029, 16'd0, stop, k, fail);
                end
                default: begin
                    add(0, 16'h0105, 16'd0, stop, k, fail);
                    if (id_val != 16'h8366) stop = 1;
                    add(0, 16'h0104, 16'd0, stop, k, fail);
                end
            endcase
        end
        fail_at = fail; tx_idx = 0;
        base = done_seen;
        @(negedge clk);
        host_op = op; host_phy = phy; host_page = page; host_reg = regi;
        host_wdata = wd; host_req = 1'b1;
        @(negedge clk);
        host_req = 1'b0;
        n = 1;
        while (!host_done && n < 2000) begin
            @(negedge clk);
            n++;
            if (poke && n == 3) begin host_req = 1'b1; host_op = 3'd1; end
            if (poke && n == 4) host_req = 1'b0;
        end
        chk(host_done, tag, "completion seen", host_done, 1);
        chk(host_err == exp_err, tag, "error flag", host_err, exp_err);
        chk(host_rdata == exp_rd, tag, "result data", host_rdata, exp_rd);
        if (exp_lat > 0) chk(n == exp_lat, "R9", "rejection latency", n, exp_lat);
        @(negedge clk);
        chk(!host_done, "R9", "done lasts one cycle", host_done, 0);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, tag, "all expected requests issued", exp_q.size(), 0);
        exp_q.delete();
        if (poke) chk(done_seen - base == 1, "R10", "busy host_req ignored", done_seen - base, 1);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual expired expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; host_req = 1'b0; host_op = '0; host_phy = '0;
        host_page = '0; host_reg = '0; host_wdata = '0;
        ctrl_r = '0; data_r = '0; id_val = 16'h8366; ver_val = 16'h00A3;
        for (int i = 0; i < 1280; i++) phymem[i] = 16'(i * 7 + 3);
        phymem[259] = 16'hC0DE;
        repeat (3) @(negedge clk);
        chk(!host_done && !host_busy && !m_req, "R9", "reset outputs idle",
            {host_done, host_busy, m_req}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R8 probe
        run_op(3'd4, 0, 0, 0, 0, -1, 1'b0, 16'h0003, "R8", 0, 0);
        id_val = 16'h8367;
        run_op(3'd4, 0, 0, 0, 0, -1, 1'b1, 16'h0000, "R8", 0, 0);
        id_val = 16'h8366;

        // R2 R3 R4 raw write / read
        run_op(3'd1, 2, 5, 17, 16'hBEEF, -1, 1'b0, 16'h0000, "R3", 0, 0);
        chk(phymem[689] == 16'hBEEF, "R3", "window write landed", phymem[689], 16'hBEEF);
        run_op(3'd0, 2, 5, 17, 0, -1, 1'b0, 16'hBEEF, "R4", 0, 0);
        run_op(3'd1, 4, 7, 31, 16'h1234, -1, 1'b0, 16'h0000, "R3", 0, 0);
        run_op(3'd0, 4, 7, 31, 0, -1, 1'b0, 16'h1234, "R4", 0, 0);

        // R1 rejections
        run_op(3'd0, 5, 0, 2, 0, -1, 1'b1, 16'h0000, "R1", 2, 0);
        run_op(3'd1, 1, 8, 2, 16'h7777, -1, 1'b1, 16'h0000, "R1", 2, 0);
        run_op(3'd0, 1, 0, 32, 0, -1, 1'b1, 16'h0000, "R1", 2, 0);
        run_op(3'd5, 1, 0, 2, 0, -1, 1'b1, 16'h0000, "R1", 2, 0);

        // R5 abort at each step
        run_op(3'd0, 1, 0, 2, 0, 0, 1'b1, 16'h0000, "R5", 0, 0);
        run_op(3'd0, 1, 0, 2, 0, 1, 1'b1, 16'h0000, "R5", 0, 0);
        run_op(3'd0, 1, 0, 2, 0, 2, 1'b1, 16'h0000, "R5", 0, 0);
        run_op(3'd1, 1, 0, 2, 16'h4444, 0, 1'b1, 16'h0000, "R5", 0, 0);

        // R6 MDIO-style reads
        run_op(3'd2, 1, 6, 3, 0, -1, 1'b0, 16'hC0DE, "R6", 0, 0);
        run_op(3'd2, 1, 0, 3, 0, 2, 1'b1, 16'hFFFF, "R6", 0, 0);
        run_op(3'd2, 7, 0, 3, 0, -1, 1'b1, 16'hFFFF, "R6", 2, 0);

        // R7 MDIO-style writes with flush
        run_op(3'd3, 3, 5, 9, 16'h5A5A, -1, 1'b0, 16'h0000, "R7", 0, 0);
        chk(phymem[777] == 16'h5A5A, "R7", "page 0 write landed", phymem[777], 16'h5A5A);
        run_op(3'd3, 3, 0, 9, 16'h1111, 1, 1'b1, 16'h0000, "R7", 0, 0);
        chk(phymem[777] == 16'h5A5A, "R7", "failed write left register", phymem[777], 16'h5A5A);
        run_op(3'd3, 3, 0, 9, 16'h2222, 3, 1'b0, 16'h0000, "R7", 0, 0);
        chk(phymem[777] == 16'h2222, "R7", "flush fault keeps write", phymem[777], 16'h2222);

        // R10 host_req while busy
        run_op(3'd0, 2, 5, 17, 0, -1, 1'b0, 16'hBEEF, "R10", 0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule